// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked single-beat request port and an 8K x 8 asynchronous static RAM. A request carries a direction, a 13-bit address and, for stores, a data byte. The controller turns each request into a timed sequence on the RAM pins: address, the active-low and active-high selects, write enable and output enable. It also drives the data bus and switches it between driving and listening. It takes one request at a time. When the RAM cycle is over it returns a one-cycle acknowledge, along with the captured byte for a load.

Every RAM timing figure is a parameter in nanoseconds, alongside the clock period. Each figure is rounded up to whole clock cycles, and a down-counter measures every phase. A parameter selects whether output enable stays low through stores, as it does on boards that tie it low. In that mode the write-enable pulse is stretched so the RAM's own drivers float before the controller drives the bus. Whenever no request is in flight, both selects are held inactive so the RAM sits in standby. All figures below use the default parameters (5 ns clock, output enable held low during stores).

Top module: `sram_ctl`

## Requirements
- R1: After reset the selects are inactive (ram_sel_n=1, ram_sel=0), ram_we_n=1, ram_oe_n=1, ram_dq_oe=0, rsp_ack=0 and req_ready=1.
- R2: Whenever req_ready is high, the RAM is in standby: selects inactive, ram_we_n=1, ram_oe_n=1 and the data driver off.
- R3: A load drives ram_sel_n=0, ram_sel=1, ram_we_n=1, ram_oe_n=0 and the request address on ram_addr, starting in the cycle after acceptance. Write enable stays high for the whole load.
- R4: A load samples ram_dq_in at the end of an access window of ceil(tAA/Tclk) cycles (4 by default). rsp_ack goes high 4 clock edges after the accepting edge, with the sampled byte on rsp_rdata.
- R5: A store first spends one setup cycle with selects active, write enable high, the address valid and output enable low. Write enable then goes low for max(tWP, tAW, tWHZ+tDW) rounded up to cycles (4 by default). Address and output data stay stable while write enable is low.
- R6: The data driver (ram_dq_oe=1) is on only while write enable is low and the RAM is selected. With output enable held low, it turns on in the 3rd cycle of the pulse (after ceil(tWHZ/Tclk)=2 cycles). It stays on for at least ceil(tDW/Tclk)=2 cycles, and turns off on the edge where write enable rises. The RAM and the controller never drive the bus together.
- R7: After write enable rises, the selects stay active for ceil(tWR/Tclk)=1 cycle before the controller deselects the RAM. A store's acknowledge arrives 6 edges after the accepting edge, and the stored byte reads back afterwards.
- R8: After a load's acknowledge, req_ready stays low for ceil(tOHZ/Tclk)=2 cycles, so the RAM's outputs have floated before a following store can drive the bus.
- R9: While a request is in flight req_ready is low. A req_valid pulse during that time is ignored: no extra acknowledge, no extra RAM cycle and no change to RAM contents.
- R10: rsp_ack is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Store data |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Loaded byte, valid with rsp_ack of a load |
| ram_addr | output | 13 | RAM address pins |
| ram_dq_out | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable for the data-bus driver |
| ram_dq_in | input | 8 | Data from the RAM |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_sel_n | output | 1 | Chip select, active low |
| ram_sel | output | 1 | Chip select, active high |

## Verification
A phase counter that is off by one shows up within a single access. If a load samples early, it captures the filler byte that the bench's RAM model presents until the access time has elapsed. If a store pulse is cut short or the driver starts early, the pulse length and drive window that the bench measures on the pins are wrong in that same pulse. A corrupted phase state either leaves the selects active while req_ready is high, or loses the acknowledge. The first is seen in the next cycle; the second ends the run at the watchdog.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WPULSE  = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_RACCESS = 3'd4,
        PH_RFLOAT  = 3'd5
    } phase_e;

    // Whole clock cycles covering a time in ns, never less than one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_rdcap.sv
`timescale 1ns/1ps
module sram_ctl_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (cap_en) data_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;
endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 3,
    parameter int C_AA      = 4,
    parameter int C_PULSE   = 4,
    parameter int C_DRV_ST  = 2,
    parameter int C_WR      = 1,
    parameter int C_OHZ     = 2,
    parameter bit OE_LOW_WR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_ack,
    input  logic [CNT_W-1:0]  tmr_cnt,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              cap_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              ram_sel_n,
    output logic              ram_sel
);
    // Driver is on in the pulse while the remaining count is at most this.
    localparam int DRV_LIM = C_PULSE - C_DRV_ST;

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dout;
        logic              we_n;
        logic              oe_n;
        logic              sel_n;
        logic              sel;
        logic              dq_oe;
        logic              ack;
    } ctl_s;

    localparam ctl_s CTL_RST = '{
        ph:    PH_IDLE,
        addr:  '0,
        dout:  '0,
        we_n:  1'b1,
        oe_n:  1'b1,
        sel_n: 1'b1,
        sel:   1'b0,
        dq_oe: 1'b0,
        ack:   1'b0
    };

    ctl_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    tmr_load  = 1'b1;
                    s_d.addr  = req_addr;
                    s_d.sel_n = 1'b0;
                    s_d.sel   = 1'b1;
                    s_d.we_n  = 1'b1;
                    if (req_write) begin
                        s_d.ph   = PH_WSETUP;
                        s_d.dout = req_wdata;
                        s_d.oe_n = !OE_LOW_WR;
                        tmr_val  = '0;
                    end else begin
                        s_d.ph   = PH_RACCESS;
                        s_d.oe_n = 1'b0;
                        tmr_val  = CNT_W'(C_AA - 1);
                    end
                end
            end
            PH_WSETUP: begin
                s_d.ph    = PH_WPULSE;
                s_d.we_n  = 1'b0;
                s_d.dq_oe = (C_DRV_ST == 0);
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(C_PULSE - 1);
            end
            PH_WPULSE: begin
                if (tmr_expired) begin
                    s_d.ph    = PH_WHOLD;
                    s_d.we_n  = 1'b1;
                    s_d.dq_oe = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(C_WR - 1);
                end else begin
                    s_d.dq_oe = ({1'b0, tmr_cnt} <= (CNT_W+1)'(DRV_LIM));
                end
            end
            PH_WHOLD: begin
                if (tmr_expired) begin
                    s_d.ph    = PH_IDLE;
                    s_d.sel_n = 1'b1;
                    s_d.sel   = 1'b0;
                    s_d.oe_n  = 1'b1;
                    s_d.ack   = 1'b1;
                end
            end
            PH_RACCESS: begin
                if (tmr_expired) begin
                    cap_en    = 1'b1;
                    s_d.ack   = 1'b1;
                    s_d.ph    = PH_RFLOAT;
                    s_d.oe_n  = 1'b1;
                    s_d.sel_n = 1'b1;
                    s_d.sel   = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(C_OHZ - 1);
                end
            end
            PH_RFLOAT: begin
                if (tmr_expired) s_d.ph = PH_IDLE;
            end
            default: s_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CTL_RST;
        else        s_q <= s_d;
    end

    assign req_ready  = (s_q.ph == PH_IDLE);
    assign rsp_ack    = s_q.ack;
    assign ram_addr   = s_q.addr;
    assign ram_dq_out = s_q.dout;
    assign ram_dq_oe  = s_q.dq_oe;
    assign ram_we_n   = s_q.we_n;
    assign ram_oe_n   = s_q.oe_n;
    assign ram_sel_n  = s_q.sel_n;
    assign ram_sel    = s_q.sel;
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int CLK_NS       = 5,
    parameter int T_AA_NS      = 20,
    parameter int T_AW_NS      = 15,
    parameter int T_WP_NS      = 15,
    parameter int T_DW_NS      = 10,
    parameter int T_WHZ_NS     = 8,
    parameter int T_OHZ_NS     = 8,
    parameter int T_WR_NS      = 5,
    parameter bit OE_LOW_WRITE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              ram_sel_n,
    output logic              ram_sel
);
    localparam int C_AA    = ns_to_cyc(T_AA_NS,  CLK_NS);
    localparam int C_AW    = ns_to_cyc(T_AW_NS,  CLK_NS);
    localparam int C_WP    = ns_to_cyc(T_WP_NS,  CLK_NS);
    localparam int C_DW    = ns_to_cyc(T_DW_NS,  CLK_NS);
    localparam int C_WHZ   = ns_to_cyc(T_WHZ_NS, CLK_NS);
    localparam int C_OHZ   = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int C_WR    = ns_to_cyc(T_WR_NS,  CLK_NS);
    localparam int C_BASE  = imax(C_WP, C_AW);
    // With output enable low the RAM must float before the driver turns on.
    localparam int C_PULSE = OE_LOW_WRITE ? imax(C_BASE, C_WHZ + C_DW)
                                          : imax(C_BASE, C_DW);
    localparam int C_DRV_ST = OE_LOW_WRITE ? C_WHZ : 0;
    localparam int C_MAX   = imax(imax(C_AA, C_PULSE), imax(C_WR, C_OHZ));
    localparam int CNT_W   = $clog2(C_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_expired;
    logic             cap_en;

    sram_ctl_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .expired  (tmr_expired)
    );

    sram_ctl_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .C_AA      (C_AA),
        .C_PULSE   (C_PULSE),
        .C_DRV_ST  (C_DRV_ST),
        .C_WR      (C_WR),
        .C_OHZ     (C_OHZ),
        .OE_LOW_WR (OE_LOW_WRITE)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .rsp_ack     (rsp_ack),
        .tmr_cnt     (tmr_cnt),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cap_en      (cap_en),
        .ram_addr    (ram_addr),
        .ram_dq_out  (ram_dq_out),
        .ram_dq_oe   (ram_dq_oe),
        .ram_we_n    (ram_we_n),
        .ram_oe_n    (ram_oe_n),
        .ram_sel_n   (ram_sel_n),
        .ram_sel     (ram_sel)
    );

    sram_ctl_rdcap #(.DATA_W(DATA_W)) rdcap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (ram_dq_in),
        .dout   (rsp_rdata)
    );
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int DW_CYC    = 2,
    parameter int PULSE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_ack,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_dq_out,
    input logic              ram_dq_oe,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic              ram_sel_n,
    input logic              ram_sel
);
    logic [15:0] we_run_q;
    logic [15:0] drv_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run_q  <= '0;
            drv_run_q <= '0;
        end else begin
            we_run_q  <= ram_we_n  ? '0 : we_run_q + 16'd1;
            drv_run_q <= ram_dq_oe ? drv_run_q + 16'd1 : '0;
        end
    end

    // R6
    drv_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> (!ram_we_n && !ram_sel_n && ram_sel));

    // R2
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_sel_n && !ram_sel && ram_we_n && ram_oe_n && !ram_dq_oe));

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |=> !rsp_ack);

    // R5
    pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ($stable(ram_addr) && $stable(ram_dq_out)));

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_run_q == 16'(PULSE_CYC)));

    // R6
    drv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (drv_run_q >= 16'(DW_CYC)));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_sel_n && ram_sel) |-> !req_ready);
endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DW_CYC    (C_DW),
    .PULSE_CYC (C_PULSE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_ack    (rsp_ack),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_sel_n  (ram_sel_n),
    .ram_sel    (ram_sel)
);

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;
    localparam int EXP_AA    = 4;
    localparam int EXP_PULSE = 4;
    localparam int EXP_DRV1  = 3;
    localparam int EXP_DRV   = 2;
    localparam int EXP_HOLD  = 1;
    localparam int EXP_WACK  = 6;
    localparam int EXP_FLOAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_ack;
    logic [7:0]  rsp_rdata;
    logic [12:0] ram_addr;
    logic [7:0]  ram_dq_out, ram_dq_in;
    logic        ram_dq_oe, ram_we_n, ram_oe_n, ram_sel_n, ram_sel;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sram_ctl dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_ack (rsp_ack), .rsp_rdata (rsp_rdata),
        .ram_addr (ram_addr), .ram_dq_out (ram_dq_out), .ram_dq_oe (ram_dq_oe),
        .ram_dq_in (ram_dq_in), .ram_we_n (ram_we_n), .ram_oe_n (ram_oe_n),
        .ram_sel_n (ram_sel_n), .ram_sel (ram_sel)
    );

    // RAM model: 256 bytes indexed by the low address byte.
    logic [7:0] mem [256];
    int  age = 0;
    int  wl_run = 0, dv_run = 0, dv_first = 0;
    int  pulse_len = 0, drv_len = 0, hold_run = 0, hold_len = 0;
    bit  in_hold = 0;
    int  ack_cnt = 0, clash_cnt = 0;
    logic [7:0] last_dout = '0;

    function automatic logic [7:0] init_pat(input logic [12:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign ram_dq_in = (age >= EXP_AA) ? mem[ram_addr[7:0]] : 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_sel_n && ram_sel && ram_we_n && !ram_oe_n) age = age + 1;
            else age = 0;
            if (ram_dq_oe && !ram_sel_n && ram_sel && ram_we_n && !ram_oe_n)
                clash_cnt = clash_cnt + 1;
            if (rsp_ack) ack_cnt = ack_cnt + 1;
            if (!ram_we_n) begin
                wl_run = wl_run + 1;
                if (ram_dq_oe) begin
                    if (dv_run == 0) dv_first = wl_run;
                    dv_run = dv_run + 1;
                    last_dout = ram_dq_out;
                end
            end else begin
                if (wl_run != 0) begin
                    pulse_len = wl_run;
                    drv_len = dv_run;
                    mem[ram_addr[7:0]] = (dv_run > 0) ? last_dout : 8'hBD;
                    in_hold = 1;
                    hold_run = 0;
                end
                wl_run = 0;
                dv_run = 0;
                if (in_hold) begin
                    if (!ram_sel_n && ram_sel) hold_run = hold_run + 1;
                    else begin hold_len = hold_run; in_hold = 0; end
                end
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 selects", {ram_sel_n, ram_sel}, 2'b10);
        chk("R1 we/oe/drv", {ram_we_n, ram_oe_n, ram_dq_oe}, 3'b110);
        chk("R1 ack/ready", {rsp_ack, req_ready}, 2'b01);
    endtask

    task automatic do_read(input logic [12:0] a, input logic [7:0] exp);
        int n, m;
        @(negedge clk);
        chk("R9 ready before load", req_ready, 1'b1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 load pins", {ram_sel_n, ram_sel, ram_we_n, ram_oe_n}, 4'b0110);
        chk("R3 load addr", ram_addr, a);
        n = 0;
        while (!rsp_ack && n < 50) begin
            @(posedge clk); n++; @(negedge clk);
            if (!rsp_ack) chk("R3 we high in load", ram_we_n, 1'b1);
        end
        chk("R4 load latency", n, EXP_AA);
        chk("R4 load data", rsp_rdata, exp);
        m = 0;
        @(posedge clk); m++; @(negedge clk);
        chk("R10 ack single", rsp_ack, 1'b0);
        while (!req_ready && m < 50) begin @(posedge clk); m++; @(negedge clk); end
        chk("R8 float wait", m, EXP_FLOAT);
        chk("R2 standby after load", {ram_sel_n, ram_sel, ram_oe_n}, 3'b101);
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d, input bit inject);
        int n;
        @(negedge clk);
        chk("R9 ready before store", req_ready, 1'b1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 setup pins", {ram_sel_n, ram_sel, ram_we_n, ram_dq_oe}, 4'b0110);
        chk("R5 setup addr", ram_addr, a);
        chk("R5 oe held low", ram_oe_n, 1'b0);
        chk("R9 busy not ready", req_ready, 1'b0);
        if (inject) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 13'h0040; req_wdata = 8'h00;
        end
        n = 0;
        while (!rsp_ack && n < 50) begin
            @(posedge clk); n++; @(negedge clk);
            req_valid = 1'b0;
        end
        chk("R7 store latency", n, EXP_WACK);
        #1;
        chk("R5 pulse length", pulse_len, EXP_PULSE);
        chk("R6 driver start", dv_first, EXP_DRV1);
        chk("R6 driver window", drv_len, EXP_DRV);
        chk("R7 select hold", hold_len, EXP_HOLD);
        chk("R2 standby after store", {ram_sel_n, ram_sel, ram_we_n, ram_dq_oe, req_ready}, 5'b10101);
    endtask

    task automatic t_plain_load();
        do_read(13'h0123, init_pat(13'h0123));
    endtask

    task automatic t_store_load();
        do_write(13'h1F05, 8'hA5, 1'b0);
        do_read(13'h1F05, 8'hA5);
        do_write(13'h1FFF, 8'h3C, 1'b0);
        do_read(13'h0000, init_pat(13'h0000));
        do_read(13'h1FFF, 8'h3C);
    endtask

    task automatic t_turnaround();
        do_read(13'h0A10, init_pat(13'h0A10));
        do_write(13'h0A11, 8'hC3, 1'b0);
        do_read(13'h0A11, 8'hC3);
        chk("R6 no bus clash", clash_cnt, 0);
    endtask

    task automatic t_ignore_busy();
        int base;
        base = ack_cnt;
        do_write(13'h0205, 8'h96, 1'b1);
        repeat (8) @(negedge clk);
        #1;
        chk("R9 one ack only", ack_cnt - base, 1);
        chk("R9 stays idle", {ram_sel_n, ram_sel, req_ready}, 3'b101);
        do_read(13'h0245, init_pat(13'h0245));
        do_read(13'h0205, 8'h96);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_plain_load();
        t_store_load();
        t_turnaround();
        t_ignore_busy();
        chk("R6 no bus clash total", clash_cnt, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R4 R7 actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule